// File: doc/BRIEF.md
# Timer Channel Capture/Compare Unit

This block is a single channel of a free-running timer. It takes the timer's shared counter value and a strobe that marks the cycles on which the counter steps. From these it either time-stamps edges seen on a pin, or drives that pin. When it drives the pin, it can act on compare matches or produce a pulse-width-modulated waveform. The counter, its clock selection and any interrupt routing sit outside the block.

Two select fields choose the behaviour. A two-bit mode field chooses the function. A two-bit level field sets the capture edge polarity or the compare pin action, and its all-zero value releases the pin. A global flag, shared by all channels of the timer, forces center-aligned PWM. Every capture or compare event sets a sticky channel flag. This flag keeps working while the pin is released, so a channel with no pin can still serve as a software timer.

Top module: `tmr_chan_unit`

## Requirements
- R1: `pin_oe_o` is 0 whenever `lvl_sel_i` is 00 or `tmr_on_i` is 0. It is also 0 in capture mode.
- R2: Mode decode works as follows. With `center_i`=1 and a nonzero `lvl_sel_i`, the channel is in center-aligned PWM and drives the pin. Otherwise, `mode_sel_i` 00 selects input capture, 01 selects output compare, and 10 or 11 select edge-aligned PWM.
- R3: In input capture, `lvl_sel_i` 01 captures on rising edges, 10 on falling edges and 11 on both edges. A capture copies `cnt_i` into `cap_o` and sets `flag_o` at the same clock edge.
- R4: A change on `pin_i` passes through a two-flop synchronizer and an edge register. It takes effect at the third rising clock edge after the change. Both edges of a high pulse lasting four clock periods are captured.
- R5: In output compare, a match (`cnt_i` == `chval_i` on an advancing cycle) acts on `pin_o` at the next edge. `lvl_sel_i` 01 toggles the pin, 10 drives it to 0 and 11 drives it to 1.
- R6: After a switch into toggle mode, `pin_o` keeps its earlier level until the first match, and only then toggles.
- R7: In output compare with `lvl_sel_i` 00, the pin is released but a match still sets `flag_o`.
- R8: Matches count only on cycles where `cnt_en_i` is 1. While `cnt_en_i` is 0, neither `pin_o` nor `flag_o` changes because of a match.
- R9: `flag_o` stays at 1 until a cycle with `flag_clr_i`=1. If an event happens in that same cycle, the event wins and the flag stays 1.
- R10: In either PWM mode, `pin_o` is updated on each advancing cycle. With `lvl_sel_i` 10 it becomes (`cnt_i` < `chval_i`). With 01 or 11 it becomes the inverse. A match also sets `flag_o`.
- R11: While `tmr_on_i` is 0, no capture or compare event occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tmr_on_i | input | 1 | Timer clock source selected (not disabled) |
| cnt_en_i | input | 1 | Counter advances on this cycle |
| cnt_i | input | CNT_W | Shared timer counter value |
| center_i | input | 1 | Global center-aligned PWM flag |
| mode_sel_i | input | 2 | Channel mode select |
| lvl_sel_i | input | 2 | Edge / pin-action select |
| chval_i | input | CNT_W | Channel compare value |
| pin_i | input | 1 | Raw pin level |
| flag_clr_i | input | 1 | One-cycle flag clear |
| pin_o | output | 1 | Pin output level |
| pin_oe_o | output | 1 | Pin drive enable |
| cap_o | output | CNT_W | Last captured counter value |
| flag_o | output | 1 | Sticky channel event flag |

## Verification
A flag clear and a new event can land on the same clock edge. The bench provokes this by raising `flag_clr_i` on the advancing cycle where the counter equals the channel value in toggle mode. It then expects the flag to read 1 and the pin to have toggled once. A capture test asserts a clear one cycle before the synchronized edge arrives. The flag must read 0 before the third edge and 1 exactly at it, with `cap_o` holding the counter value presented at that edge.

// File: rtl/tmr_chan_pkg.sv
package tmr_chan_pkg;
  typedef enum logic [1:0] {
    CM_CAPTURE = 2'd0,
    CM_COMPARE = 2'd1,
    CM_EPWM    = 2'd2,
    CM_CPWM    = 2'd3
  } chan_mode_e;

  localparam logic [1:0] LVL_OFF = 2'b00;
  localparam logic [1:0] LVL_A   = 2'b01;  // rising / toggle / low-true PWM
  localparam logic [1:0] LVL_B   = 2'b10;  // falling / clear / high-true PWM
  localparam logic [1:0] LVL_C   = 2'b11;  // both / set / low-true PWM
endpackage

// File: rtl/tmr_chan_decode.sv
module tmr_chan_decode
  import tmr_chan_pkg::*;
(
  input  logic       tmr_on_i,
  input  logic       center_i,
  input  logic [1:0] mode_sel_i,
  input  logic [1:0] lvl_sel_i,
  output chan_mode_e mode_o,
  output logic       drive_o,
  output logic       rise_en_o,
  output logic       fall_en_o
);
  always_comb begin
    if (center_i && (lvl_sel_i != LVL_OFF)) begin
      mode_o = CM_CPWM;
    end else begin
      unique case (mode_sel_i)
        2'b00:   mode_o = CM_CAPTURE;
        2'b01:   mode_o = CM_COMPARE;
        default: mode_o = CM_EPWM;
      endcase
    end
  end

  always_comb begin
    drive_o   = tmr_on_i && (lvl_sel_i != LVL_OFF) && (mode_o != CM_CAPTURE);
    rise_en_o = tmr_on_i && (mode_o == CM_CAPTURE) && lvl_sel_i[0];
    fall_en_o = tmr_on_i && (mode_o == CM_CAPTURE) && lvl_sel_i[1];
  end
endmodule

// File: rtl/tmr_chan_sync_edge.sv
module tmr_chan_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic rise_o,
  output logic fall_o
);
  localparam int TOP = STAGES - 1;

  logic [TOP:0] sync_q, sync_d;
  logic         last_q, last_d;

  always_comb begin
    sync_d = {sync_q[TOP-1:0], pin_i};
    last_d = sync_q[TOP];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      last_q <= last_d;
    end
  end

  assign rise_o = sync_q[TOP] & ~last_q;
  assign fall_o = ~sync_q[TOP] & last_q;
endmodule

// File: rtl/tmr_chan_out.sv
module tmr_chan_out
  import tmr_chan_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  chan_mode_e mode_i,
  input  logic [1:0] lvl_sel_i,
  input  logic       adv_i,
  input  logic       match_i,
  input  logic       below_i,
  output logic       pin_o
);
  logic pin_q, pin_d, pin_en;

  always_comb begin
    pin_d  = pin_q;
    pin_en = 1'b0;
    unique case (mode_i)
      CM_COMPARE: begin
        pin_en = adv_i && match_i;
        unique case (lvl_sel_i)
          LVL_A:   pin_d = ~pin_q;
          LVL_B:   pin_d = 1'b0;
          LVL_C:   pin_d = 1'b1;
          default: pin_d = pin_q;
        endcase
      end
      CM_EPWM, CM_CPWM: begin
        pin_en = adv_i;
        pin_d  = below_i ^ lvl_sel_i[0];
      end
      default: begin
        pin_en = 1'b0;
        pin_d  = pin_q;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_q <= 1'b0;
    end else if (pin_en) begin
      pin_q <= pin_d;
    end
  end

  assign pin_o = pin_q;
endmodule

// File: rtl/tmr_chan_unit.sv
module tmr_chan_unit
  import tmr_chan_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tmr_on_i,
  input  logic             cnt_en_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             center_i,
  input  logic [1:0]       mode_sel_i,
  input  logic [1:0]       lvl_sel_i,
  input  logic [CNT_W-1:0] chval_i,
  input  logic             pin_i,
  input  logic             flag_clr_i,
  output logic             pin_o,
  output logic             pin_oe_o,
  output logic [CNT_W-1:0] cap_o,
  output logic             flag_o
);
  chan_mode_e mode;
  logic       drive, rise_en, fall_en;
  logic       rise, fall;
  logic       adv, match, below;
  logic       cmp_evt, cap_evt;

  logic             flag_q, flag_d;
  logic [CNT_W-1:0] cap_q, cap_d;

  tmr_chan_decode u_decode (
    .tmr_on_i   (tmr_on_i),
    .center_i   (center_i),
    .mode_sel_i (mode_sel_i),
    .lvl_sel_i  (lvl_sel_i),
    .mode_o     (mode),
    .drive_o    (drive),
    .rise_en_o  (rise_en),
    .fall_en_o  (fall_en)
  );

  tmr_chan_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .pin_i  (pin_i),
    .rise_o (rise),
    .fall_o (fall)
  );

  always_comb begin
    adv     = cnt_en_i && tmr_on_i;
    match   = (cnt_i == chval_i);
    below   = (cnt_i < chval_i);
    cmp_evt = adv && match && (mode != CM_CAPTURE);
    cap_evt = (rise && rise_en) || (fall && fall_en);
  end

  tmr_chan_out u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_i    (mode),
    .lvl_sel_i (lvl_sel_i),
    .adv_i     (adv),
    .match_i   (match),
    .below_i   (below),
    .pin_o     (pin_o)
  );

  always_comb begin
    if (cmp_evt || cap_evt) begin
      flag_d = 1'b1;
    end else if (flag_clr_i) begin
      flag_d = 1'b0;
    end else begin
      flag_d = flag_q;
    end
    cap_d = cap_evt ? cnt_i : cap_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      cap_q  <= '0;
    end else begin
      flag_q <= flag_d;
      if (cap_evt) begin
        cap_q <= cap_d;
      end
    end
  end

  assign pin_oe_o = drive;
  assign cap_o    = cap_q;
  assign flag_o   = flag_q;
endmodule

// File: rtl/tmr_chan_unit_chk.sv
module tmr_chan_unit_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tmr_on_i,
  input logic             cnt_en_i,
  input logic [CNT_W-1:0] cnt_i,
  input logic             center_i,
  input logic [1:0]       mode_sel_i,
  input logic [1:0]       lvl_sel_i,
  input logic [CNT_W-1:0] chval_i,
  input logic             flag_clr_i,
  input logic             pin_o,
  input logic             pin_oe_o,
  input logic [CNT_W-1:0] cap_o,
  input logic             flag_o
);
  // R1
  pin_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((lvl_sel_i == 2'b00) || !tmr_on_i) |-> !pin_oe_o);

  // R9
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_o && !flag_clr_i) |=> flag_o);

  // R9
  flag_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag_o) |-> $past(flag_clr_i));

  // R8
  pin_still_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cnt_en_i && tmr_on_i) |=> $stable(pin_o));

  // R5
  oc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_on_i && cnt_en_i && !center_i && mode_sel_i == 2'b01 &&
     lvl_sel_i == 2'b10 && cnt_i == chval_i) |=> !pin_o);

  // R5
  oc_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_on_i && cnt_en_i && !center_i && mode_sel_i == 2'b01 &&
     lvl_sel_i == 2'b11 && cnt_i == chval_i) |=> pin_o);

  // R3
  cap_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cap_o) |-> $past(!center_i && mode_sel_i == 2'b00 && lvl_sel_i != 2'b00));

  // R11
  timer_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_o) |-> $past(tmr_on_i));
endmodule

bind tmr_chan_unit tmr_chan_unit_chk #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .tmr_on_i   (tmr_on_i),
  .cnt_en_i   (cnt_en_i),
  .cnt_i      (cnt_i),
  .center_i   (center_i),
  .mode_sel_i (mode_sel_i),
  .lvl_sel_i  (lvl_sel_i),
  .chval_i    (chval_i),
  .flag_clr_i (flag_clr_i),
  .pin_o      (pin_o),
  .pin_oe_o   (pin_oe_o),
  .cap_o      (cap_o),
  .flag_o     (flag_o)
);

// File: tb/tmr_chan_unit_bench.sv
module tmr_chan_unit_bench;
  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          tmr_on_i, cnt_en_i, center_i, pin_i, flag_clr_i;
  logic [CW-1:0] cnt_i, chval_i;
  logic [1:0]    mode_sel_i, lvl_sel_i;
  logic          pin_o, pin_oe_o, flag_o;
  logic [CW-1:0] cap_o;

  int  checks = 0;
  int  errors = 0;
  bit  done   = 0;

  always #4 clk = ~clk;

  tmr_chan_unit #(.CNT_W(CW)) u_tmr_chan_unit (
    .clk(clk), .rst_n(rst_n), .tmr_on_i(tmr_on_i), .cnt_en_i(cnt_en_i),
    .cnt_i(cnt_i), .center_i(center_i), .mode_sel_i(mode_sel_i),
    .lvl_sel_i(lvl_sel_i), .chval_i(chval_i), .pin_i(pin_i),
    .flag_clr_i(flag_clr_i), .pin_o(pin_o), .pin_oe_o(pin_oe_o),
    .cap_o(cap_o), .flag_o(flag_o)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic clear_flag();
    flag_clr_i = 1'b1;
    cnt_en_i   = 1'b0;
    tick();
    flag_clr_i = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic          pin_m;
    logic [CW-1:0] cap_m;
    int            seq [6] = '{3, 2, 1, 1, 3, 1};

    rst_n = 1'b0; tmr_on_i = 1'b1; cnt_en_i = 1'b0; center_i = 1'b0;
    pin_i = 1'b0; flag_clr_i = 1'b0; cnt_i = '0; chval_i = '0;
    mode_sel_i = 2'b00; lvl_sel_i = 2'b00;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    check("reset pin_o", pin_o, 0);
    check("reset flag_o", flag_o, 0);
    check("reset cap_o", cap_o, 0);
    check("R1 reset oe", pin_oe_o, 0);

    // R1 / R2 decode
    mode_sel_i = 2'b01; lvl_sel_i = 2'b00; tick();
    check("R1 oc lvl 00 released", pin_oe_o, 0);
    lvl_sel_i = 2'b10; tmr_on_i = 1'b0; tick();
    check("R1 timer off released", pin_oe_o, 0);
    tmr_on_i = 1'b1; tick();
    check("R2 oc drives", pin_oe_o, 1);
    mode_sel_i = 2'b00; lvl_sel_i = 2'b01; tick();
    check("R2 capture not driven", pin_oe_o, 0);
    mode_sel_i = 2'b10; tick();
    check("R2 epwm 10 drives", pin_oe_o, 1);
    mode_sel_i = 2'b11; tick();
    check("R2 epwm 11 drives", pin_oe_o, 1);
    center_i = 1'b1; mode_sel_i = 2'b00; lvl_sel_i = 2'b10; tick();
    check("R2 cpwm overrides capture", pin_oe_o, 1);
    lvl_sel_i = 2'b00; tick();
    check("R2 cpwm lvl 00 released", pin_oe_o, 0);
    center_i = 1'b0;

    // R5 / R6 output compare sweeps
    pin_m = 1'b0;
    chval_i = 16'd5; mode_sel_i = 2'b01;
    for (int p = 0; p < 6; p++) begin
      lvl_sel_i = seq[p][1:0];
      for (int k = 0; k < 8; k++) begin
        cnt_i = k[CW-1:0]; cnt_en_i = 1'b1;
        tick();
        if (k == 5) begin
          case (seq[p])
            1: pin_m = ~pin_m;
            2: pin_m = 1'b0;
            default: pin_m = 1'b1;
          endcase
        end
        if (seq[p] == 1) check("R6 toggle hold/act", pin_o, pin_m);
        else check("R5 compare action", pin_o, pin_m);
      end
      check("R5 match flag", flag_o, 1);
      clear_flag();
    end

    // R8 no action without advance
    lvl_sel_i = 2'b01; cnt_i = 16'd5; cnt_en_i = 1'b0;
    for (int k = 0; k < 3; k++) begin
      tick();
      check("R8 pin idle", pin_o, pin_m);
      check("R8 flag idle", flag_o, 0);
    end
    cnt_en_i = 1'b1; tick(); pin_m = ~pin_m;
    check("R8 single toggle", pin_o, pin_m);
    check("R8 flag on advance", flag_o, 1);
    cnt_en_i = 1'b0;

    // R9 sticky flag and collision
    repeat (3) tick();
    check("R9 flag sticky", flag_o, 1);
    clear_flag();
    check("R9 flag cleared", flag_o, 0);
    flag_clr_i = 1'b1; cnt_en_i = 1'b1; cnt_i = 16'd5;
    tick(); pin_m = ~pin_m;
    flag_clr_i = 1'b0; cnt_en_i = 1'b0;
    check("R9 event beats clear", flag_o, 1);
    check("R9 collision toggle", pin_o, pin_m);
    clear_flag();

    // R7 software timer
    lvl_sel_i = 2'b00; cnt_i = 16'd5; cnt_en_i = 1'b1; tick(); cnt_en_i = 1'b0;
    check("R7 soft timer flag", flag_o, 1);
    check("R7 soft timer released", pin_oe_o, 0);
    clear_flag();

    // R11 timer off compare
    tmr_on_i = 1'b0; lvl_sel_i = 2'b10; cnt_en_i = 1'b1; tick(); cnt_en_i = 1'b0;
    check("R11 no compare event", flag_o, 0);
    check("R11 pin unchanged", pin_o, pin_m);
    tmr_on_i = 1'b1;

    // R3 / R4 capture edge selection
    cap_m = cap_o;
    mode_sel_i = 2'b00;
    for (int e = 1; e < 4; e++) begin
      for (int ed = 0; ed < 2; ed++) begin
        logic [CW-1:0] v;
        bit            en;
        lvl_sel_i = e[1:0];
        clear_flag();
        v = 16'h1000 + CW'(e * 16 + ed);
        en = (ed == 0) ? e[0] : e[1];
        cnt_i = v; pin_i = ~pin_i;
        tick(); check("R4 not yet (1)", flag_o, 0);
        tick(); check("R4 not yet (2)", flag_o, 0);
        tick();
        check("R3 edge select flag", flag_o, {31'd0, en});
        if (en) cap_m = v;
        check("R3 captured value", cap_o, cap_m);
        tick();
      end
    end

    // R4 four-cycle pulse, both edges
    lvl_sel_i = 2'b11; clear_flag();
    for (int i = 0; i < 8; i++) begin
      cnt_i = 16'd100 + CW'(i);
      pin_i = (i < 4);
      tick();
      if (i == 3) check("R4 pulse rise capture", cap_o, 102);
      if (i == 7) check("R4 pulse fall capture", cap_o, 106);
    end
    cap_m = cap_o;

    // R11 timer off capture
    clear_flag();
    tmr_on_i = 1'b0; pin_i = 1'b1;
    repeat (4) tick();
    check("R11 no capture flag", flag_o, 0);
    check("R11 capture unchanged", cap_o, cap_m);
    tmr_on_i = 1'b1; pin_i = 1'b1; tick();

    // R10 edge-aligned PWM
    mode_sel_i = 2'b10; chval_i = 16'd4;
    for (int pol = 0; pol < 2; pol++) begin
      lvl_sel_i = (pol == 0) ? 2'b10 : 2'b01;
      clear_flag();
      for (int k = 0; k < 10; k++) begin
        cnt_i = k[CW-1:0]; cnt_en_i = 1'b1;
        tick();
        check("R10 epwm level", pin_o, {31'd0, (k < 4) ^ (pol == 1)});
      end
      check("R10 epwm match flag", flag_o, 1);
    end

    // R10 center-aligned PWM, up then down
    center_i = 1'b1; mode_sel_i = 2'b00; lvl_sel_i = 2'b10; chval_i = 16'd3;
    for (int s = 0; s < 13; s++) begin
      int k;
      k = (s < 7) ? s : 12 - s;
      cnt_i = k[CW-1:0]; cnt_en_i = 1'b1;
      tick();
      check("R10 cpwm level", pin_o, {31'd0, k < 3});
    end
    cnt_en_i = 1'b0;

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule